// File: doc/BRIEF.md
# Multithreaded Delay-Slot Fetch Sequencer

This block produces the fetch address stream for a small in-order pipeline that runs several hardware threads on an instruction set with branch delay slots. Each thread keeps three sequential addresses: the current, the next and the one after. Each thread also has a deferred redirect target, which is held back until its delay slot has been fetched. On each fetch request, a round-robin arbiter picks one thread among those that are active and hold a valid PC. The block then returns that thread's address, its predicted next target and its own incrementing sequence number.

Branch information arrives from a later stage, at most one branch per cycle. Each branch is marked as control or not, as a return, as a conditional-delay ("likely") type, and as predicted taken, and it carries its target. From this information the block arms the delay-slot countdown, requests squashes of younger instructions, or blocks a stage until an unresolved return is fixed. Several squash ports can fire in the same cycle. For each thread the oldest squash wins, and it restarts the thread either at a new address or at the delay slot that must be replayed.

Top module: `dslot_fetch_seq`

## Requirements
- R1: After reset no thread is active. A fetch request then gives fetch_stall=1 and fetch_valid=0, and no unblock bit is raised.
- R2: Activating a thread loads its three addresses from act_pc/act_npc/act_nnpc, zeroes its sequence counter and makes it eligible. Eligible threads are granted in rotation, starting after the last granted thread.
- R3: A fetch with no pending redirect returns fetch_addr=PC and fetch_pred=NNPC, plus the thread's sequence number, which then increments. The thread then advances: PC takes NPC, NPC takes NNPC, and NNPC grows by ISZ.
- R4: Each fetch made while the delay countdown is nonzero decrements it, and reaching zero arms the deferred target. The next fetch of that thread returns the target T with fetch_pred=T+2*ISZ, and the thread continues from T+ISZ.
- R5: A control branch predicted taken adds one to the countdown and stores its target as the deferred target. In the same cycle it raises sq_req_valid with sq_req_seq = br_seq+1.
- R6: A control branch predicted not taken that is neither a return nor likely stores br_pc+2*ISZ as the deferred target, adds one to the countdown, and raises no squash request.
- R7: A likely branch predicted not taken raises sq_req_valid with sq_req_seq = br_seq and leaves the thread's addresses unchanged.
- R8: A return not predicted taken pulses blk_valid in the same cycle, with blk_tid and blk_stage taken from the branch. The thread is then not granted until a squash is accepted for it.
- R9: Squash port p uses bit p of sq_v/sq_ctrl/sq_replay and the slices [p*W +: W] of sq_tid, sq_seq, sq_pc and sq_target. Per thread, only the valid port with the lowest sequence number is accepted; on a tie the lower port index wins.
- R10: An accepted squash restarts at sq_target when sq_ctrl=1, otherwise at sq_pc+ISZ, with NPC and NNPC set one and two sizes beyond the restart address. It makes PC valid again. If the thread was blocked, it sets that thread's ublk_valid bit, with ublk_stage equal to the recorded block stage.
- R11: An accepted squash with sq_replay=1 restarts at the delay slot sq_pc+ISZ, with the countdown set to one and sq_target deferred, so fetches return sq_pc+ISZ and then sq_target.
- R12: A deactivated thread is never granted. Branch and squash inputs aimed at it have no effect: no squash request, no unblock, and no change to the grants that follow.
- R13: Branch information with br_ctrl=0 changes nothing and raises no squash request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| act_valid | input | 1 | Activate a thread |
| act_tid | input | TW | Thread to activate |
| act_pc | input | AW | Initial PC |
| act_npc | input | AW | Initial next PC |
| act_nnpc | input | AW | Initial next-next PC |
| deact_valid | input | 1 | Deactivate a thread |
| deact_tid | input | TW | Thread to deactivate |
| fetch_req | input | 1 | Fetch request |
| fetch_valid | output | 1 | A thread was granted |
| fetch_stall | output | 1 | Request with no eligible thread |
| fetch_tid | output | TW | Granted thread |
| fetch_addr | output | AW | Fetch address |
| fetch_pred | output | AW | Predicted next target |
| fetch_seq | output | SEQW | Sequence number |
| br_valid | input | 1 | Branch information valid |
| br_tid | input | TW | Branch thread |
| br_ctrl | input | 1 | Instruction is control |
| br_ret | input | 1 | Instruction is a return |
| br_likely | input | 1 | Conditional-delay (likely) type |
| br_taken | input | 1 | Predicted taken |
| br_pc | input | AW | Branch address |
| br_target | input | AW | Predicted target |
| br_seq | input | SEQW | Branch sequence number |
| br_stage | input | SW | Stage that holds the branch |
| blk_valid | output | 1 | Block pulse for a stage |
| blk_tid | output | TW | Blocked thread |
| blk_stage | output | SW | Stage to block |
| sq_req_valid | output | 1 | Squash request |
| sq_req_tid | output | TW | Thread to squash |
| sq_req_seq | output | SEQW | Squash everything younger than this |
| sq_req_stage | output | SW | Stage the squash starts from |
| sq_v | input | NSQ | Squash port valid bits |
| sq_tid | input | NSQ*TW | Squash thread per port |
| sq_seq | input | NSQ*SEQW | Squash sequence per port |
| sq_ctrl | input | NSQ | Squashing instruction is control |
| sq_replay | input | NSQ | Replay delay slot on mispredict |
| sq_pc | input | NSQ*AW | Squashing instruction address |
| sq_target | input | NSQ*AW | Squashing instruction target |
| ublk_valid | output | NTHR | Unblock pulse per thread |
| ublk_stage | output | NTHR*SW | Stage to unblock per thread |

## Verification
The assertions assume that activation is the only event that restarts a thread's sequence counter. They also assume that a return blocks its thread for at least one cycle, unless a squash arrives in the same cycle. The stimulus keeps to these assumptions. It never activates a thread in the same cycle as a block, and it never presents branch information and a fetch of the same thread together, so countdown updates never compete with fetch decrements. Squash arrivals are kept apart from branch cycles, so the bench's expected addresses follow one event at a time.

// File: rtl/dslot_fetch_seq.sv
`timescale 1ns/1ps
module dslot_fetch_seq #(
  parameter int NTHR = 2,
  parameter int AW   = 32,
  parameter int SEQW = 8,
  parameter int ISZ  = 4,
  parameter int NSTG = 4,
  parameter int NSQ  = 2,
  parameter int DCW  = 2,
  localparam int TW  = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int SW  = (NSTG > 1) ? $clog2(NSTG) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               act_valid,
  input  logic [TW-1:0]      act_tid,
  input  logic [AW-1:0]      act_pc,
  input  logic [AW-1:0]      act_npc,
  input  logic [AW-1:0]      act_nnpc,
  input  logic               deact_valid,
  input  logic [TW-1:0]      deact_tid,
  input  logic               fetch_req,
  output logic               fetch_valid,
  output logic               fetch_stall,
  output logic [TW-1:0]      fetch_tid,
  output logic [AW-1:0]      fetch_addr,
  output logic [AW-1:0]      fetch_pred,
  output logic [SEQW-1:0]    fetch_seq,
  input  logic               br_valid,
  input  logic [TW-1:0]      br_tid,
  input  logic               br_ctrl,
  input  logic               br_ret,
  input  logic               br_likely,
  input  logic               br_taken,
  input  logic [AW-1:0]      br_pc,
  input  logic [AW-1:0]      br_target,
  input  logic [SEQW-1:0]    br_seq,
  input  logic [SW-1:0]      br_stage,
  output logic               blk_valid,
  output logic [TW-1:0]      blk_tid,
  output logic [SW-1:0]      blk_stage,
  output logic               sq_req_valid,
  output logic [TW-1:0]      sq_req_tid,
  output logic [SEQW-1:0]    sq_req_seq,
  output logic [SW-1:0]      sq_req_stage,
  input  logic [NSQ-1:0]     sq_v,
  input  logic [NSQ*TW-1:0]  sq_tid,
  input  logic [NSQ*SEQW-1:0] sq_seq,
  input  logic [NSQ-1:0]     sq_ctrl,
  input  logic [NSQ-1:0]     sq_replay,
  input  logic [NSQ*AW-1:0]  sq_pc,
  input  logic [NSQ*AW-1:0]  sq_target,
  output logic [NTHR-1:0]    ublk_valid,
  output logic [NTHR*SW-1:0] ublk_stage
);
  localparam int PW = (NSQ > 1) ? $clog2(NSQ) : 1;
  localparam logic [AW-1:0] I1 = AW'(ISZ);
  localparam logic [AW-1:0] I2 = AW'(2 * ISZ);
  localparam logic [AW-1:0] I3 = AW'(3 * ISZ);

  logic [AW-1:0]   pc_q   [NTHR];
  logic [AW-1:0]   npc_q  [NTHR];
  logic [AW-1:0]   nnpc_q [NTHR];
  logic [AW-1:0]   tgt_q  [NTHR];
  logic [DCW-1:0]  cnt_q  [NTHR];
  logic [SW-1:0]   bstg_q [NTHR];
  logic [SEQW-1:0] seq_q  [NTHR];
  logic [NTHR-1:0] rdy_q, vld_q, act_q;
  logic [TW-1:0]   last_q;

  logic [NTHR-1:0] elig;
  logic            gnt_found;
  logic [TW-1:0]   gnt_tid;
  logic            redir;

  assign elig = act_q & vld_q;

  always_comb begin
    gnt_found = 1'b0;
    gnt_tid   = last_q;
    for (int i = 1; i <= NTHR; i++) begin
      if (!gnt_found && elig[TW'((int'(last_q) + i) % NTHR)]) begin
        gnt_found = 1'b1;
        gnt_tid   = TW'((int'(last_q) + i) % NTHR);
      end
    end
  end

  assign fetch_valid = fetch_req & gnt_found;
  assign fetch_stall = fetch_req & ~gnt_found;
  assign fetch_tid   = gnt_tid;
  assign redir       = rdy_q[gnt_tid] && (cnt_q[gnt_tid] == '0);
  assign fetch_addr  = redir ? tgt_q[gnt_tid] : pc_q[gnt_tid];
  assign fetch_pred  = redir ? tgt_q[gnt_tid] + I2 : nnpc_q[gnt_tid];
  assign fetch_seq   = seq_q[gnt_tid];

  logic br_go, br_block, br_tk, br_lnt, br_nnt;
  assign br_go    = br_valid & br_ctrl & act_q[br_tid];
  assign br_block = br_go & br_ret & ~br_taken;
  assign br_tk    = br_go & br_taken;
  assign br_lnt   = br_go & ~br_ret & ~br_taken & br_likely;
  assign br_nnt   = br_go & ~br_ret & ~br_taken & ~br_likely;

  assign blk_valid    = br_block;
  assign blk_tid      = br_tid;
  assign blk_stage    = br_stage;
  assign sq_req_valid = br_tk | br_lnt;
  assign sq_req_tid   = br_tid;
  assign sq_req_seq   = br_tk ? br_seq + SEQW'(1) : br_seq;
  assign sq_req_stage = br_stage;

  logic [NTHR-1:0] sel_hit;
  logic [PW-1:0]   sel_p    [NTHR];
  logic [SEQW-1:0] sel_seq  [NTHR];
  logic [AW-1:0]   rst_addr [NTHR];
  logic [AW-1:0]   rpl_tgt  [NTHR];
  logic [NTHR-1:0] rpl;

  always_comb begin
    for (int t = 0; t < NTHR; t++) begin
      sel_hit[t] = 1'b0;
      sel_p[t]   = '0;
      sel_seq[t] = '0;
      for (int p = 0; p < NSQ; p++) begin
        if (sq_v[p] && sq_tid[p*TW +: TW] == TW'(t) && act_q[t] &&
            (!sel_hit[t] || sq_seq[p*SEQW +: SEQW] < sel_seq[t])) begin
          sel_hit[t] = 1'b1;
          sel_p[t]   = PW'(p);
          sel_seq[t] = sq_seq[p*SEQW +: SEQW];
        end
      end
      rpl[t]      = sq_replay[sel_p[t]];
      rpl_tgt[t]  = sq_target[sel_p[t]*AW +: AW];
      rst_addr[t] = (sq_ctrl[sel_p[t]] && !rpl[t]) ? rpl_tgt[t]
                                                   : sq_pc[sel_p[t]*AW +: AW] + I1;
      ublk_valid[t] = sel_hit[t] & ~vld_q[t];
      ublk_stage[t*SW +: SW] = bstg_q[t];
    end
  end

  logic [NTHR-1:0] issue;
  always_comb begin
    for (int t = 0; t < NTHR; t++) issue[t] = fetch_valid && (gnt_tid == TW'(t));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      act_q  <= '0;
      vld_q  <= '0;
      rdy_q  <= '0;
      for (int t = 0; t < NTHR; t++) begin
        pc_q[t]   <= '0;
        npc_q[t]  <= '0;
        nnpc_q[t] <= '0;
        tgt_q[t]  <= '0;
        cnt_q[t]  <= '0;
        bstg_q[t] <= '0;
        seq_q[t]  <= '0;
      end
    end else begin
      if (fetch_valid) last_q <= gnt_tid;
      for (int t = 0; t < NTHR; t++) begin
        if (deact_valid && deact_tid == TW'(t)) begin
          act_q[t]  <= 1'b0;
          vld_q[t]  <= 1'b0;
          rdy_q[t]  <= 1'b0;
          cnt_q[t]  <= '0;
          bstg_q[t] <= '0;
        end else if (act_valid && act_tid == TW'(t)) begin
          act_q[t]  <= 1'b1;
          vld_q[t]  <= 1'b1;
          rdy_q[t]  <= 1'b0;
          cnt_q[t]  <= '0;
          seq_q[t]  <= '0;
          pc_q[t]   <= act_pc;
          npc_q[t]  <= act_npc;
          nnpc_q[t] <= act_nnpc;
        end else begin
          if (issue[t]) seq_q[t] <= seq_q[t] + SEQW'(1);
          if (sel_hit[t]) begin
            vld_q[t]  <= 1'b1;
            rdy_q[t]  <= 1'b0;
            pc_q[t]   <= rst_addr[t];
            npc_q[t]  <= rst_addr[t] + I1;
            nnpc_q[t] <= rst_addr[t] + I2;
            cnt_q[t]  <= rpl[t] ? DCW'(1) : '0;
            if (rpl[t]) tgt_q[t] <= rpl_tgt[t];
          end else begin
            if (issue[t]) begin
              if (redir) begin
                rdy_q[t]  <= 1'b0;
                pc_q[t]   <= tgt_q[t] + I1;
                npc_q[t]  <= tgt_q[t] + I2;
                nnpc_q[t] <= tgt_q[t] + I3;
              end else begin
                pc_q[t]   <= npc_q[t];
                npc_q[t]  <= nnpc_q[t];
                nnpc_q[t] <= nnpc_q[t] + I1;
                if (cnt_q[t] != '0) begin
                  cnt_q[t] <= cnt_q[t] - DCW'(1);
                  rdy_q[t] <= (cnt_q[t] == DCW'(1));
                end
              end
            end
            if (br_tid == TW'(t)) begin
              if (br_block) begin
                vld_q[t]  <= 1'b0;
                bstg_q[t] <= br_stage;
              end
              if (br_tk || br_nnt) begin
                cnt_q[t] <= ((issue[t] && cnt_q[t] != '0) ? cnt_q[t] - DCW'(1) : cnt_q[t]) + DCW'(1);
                rdy_q[t] <= 1'b0;
                tgt_q[t] <= br_tk ? br_target : br_pc + I2;
              end
            end
          end
        end
      end
    end
  end
endmodule

module dslot_fetch_seq_chk #(
  parameter int NTHR = 2,
  parameter int SEQW = 8,
  parameter int NSQ  = 2,
  parameter int TW   = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fetch_valid,
  input logic            fetch_stall,
  input logic [TW-1:0]   fetch_tid,
  input logic [SEQW-1:0] fetch_seq,
  input logic            act_valid,
  input logic            br_valid,
  input logic            br_ctrl,
  input logic            br_taken,
  input logic            br_likely,
  input logic [SEQW-1:0] br_seq,
  input logic            blk_valid,
  input logic [TW-1:0]   blk_tid,
  input logic            sq_req_valid,
  input logic [SEQW-1:0] sq_req_seq,
  input logic [NSQ-1:0]  sq_v,
  input logic [NTHR-1:0] ublk_valid
);
  p_stall_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall |-> !fetch_valid);

  p_seq_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && $past(fetch_valid) && fetch_tid == $past(fetch_tid) && !$past(act_valid))
    |-> fetch_seq == SEQW'($past(fetch_seq) + 1'b1));

  p_taken_seq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_req_valid && br_taken) |-> sq_req_seq == SEQW'(br_seq + 1'b1));

  p_sq_source_r13: assert property (@(posedge clk) disable iff (!rst_n)
    sq_req_valid |-> (br_valid && br_ctrl && (br_taken || br_likely)));

  p_block_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && !(|sq_v) && !act_valid) |=> !(fetch_valid && fetch_tid == $past(blk_tid)));

  p_unblock_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|ublk_valid) |-> (|sq_v));
endmodule

bind dslot_fetch_seq dslot_fetch_seq_chk #(.NTHR(NTHR), .SEQW(SEQW), .NSQ(NSQ), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_stall(fetch_stall),
  .fetch_tid(fetch_tid), .fetch_seq(fetch_seq), .act_valid(act_valid),
  .br_valid(br_valid), .br_ctrl(br_ctrl), .br_taken(br_taken), .br_likely(br_likely),
  .br_seq(br_seq), .blk_valid(blk_valid), .blk_tid(blk_tid),
  .sq_req_valid(sq_req_valid), .sq_req_seq(sq_req_seq), .sq_v(sq_v), .ublk_valid(ublk_valid));

// File: tb/test_dslot_fetch_seq.sv
`timescale 1ns/1ps
module test_dslot_fetch_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic act_valid, deact_valid, fetch_req, br_valid, br_ctrl, br_ret, br_likely, br_taken;
  logic act_tid, deact_tid, br_tid;
  logic [31:0] act_pc, act_npc, act_nnpc, br_pc, br_target;
  logic [7:0] br_seq;
  logic [1:0] br_stage;
  logic fetch_valid, fetch_stall, fetch_tid, blk_valid, blk_tid, sq_req_valid, sq_req_tid;
  logic [31:0] fetch_addr, fetch_pred;
  logic [7:0] fetch_seq, sq_req_seq;
  logic [1:0] blk_stage, sq_req_stage;
  logic [1:0] sq_v, sq_tid, sq_ctrl, sq_replay, ublk_valid;
  logic [15:0] sq_seq;
  logic [63:0] sq_pc, sq_target;
  logic [3:0] ublk_stage;

  dslot_fetch_seq i_dslot_fetch_seq (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    act_valid = 0; act_tid = 0; act_pc = 0; act_npc = 0; act_nnpc = 0;
    deact_valid = 0; deact_tid = 0; fetch_req = 0;
    br_valid = 0; br_tid = 0; br_ctrl = 0; br_ret = 0; br_likely = 0; br_taken = 0;
    br_pc = 0; br_target = 0; br_seq = 0; br_stage = 0;
    sq_v = 0; sq_tid = 0; sq_seq = 0; sq_ctrl = 0; sq_replay = 0; sq_pc = 0; sq_target = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic sq(int p, logic tid, logic [7:0] s, logic c, logic r, logic [31:0] a, logic [31:0] t);
    sq_v[p] = 1; sq_tid[p] = tid; sq_seq[p*8 +: 8] = s; sq_ctrl[p] = c; sq_replay[p] = r;
    sq_pc[p*32 +: 32] = a; sq_target[p*32 +: 32] = t;
  endtask

  task automatic fetch(string req, logic tid, logic [31:0] a);
    idle(); fetch_req = 1; #1;
    chk({req, " valid"}, 32'(fetch_valid), 1);
    chk({req, " tid"}, 32'(fetch_tid), 32'(tid));
    chk({req, " addr"}, fetch_addr, a);
    tick();
  endtask

  typedef struct packed { logic [2:0] k; logic [31:0] a; logic [31:0] b; logic [7:0] s; } row_t;
  localparam int NROW = 18;
  localparam row_t TAB [NROW] = '{
    '{3'd0, 32'h100, 32'h108, 8'd0},  '{3'd0, 32'h104, 32'h10C, 8'd1},
    '{3'd1, 32'h104, 32'h200, 8'd1},  '{3'd0, 32'h108, 32'h110, 8'd2},
    '{3'd0, 32'h200, 32'h208, 8'd3},  '{3'd0, 32'h204, 32'h20C, 8'd4},
    '{3'd2, 32'h204, 32'h0,   8'd4},  '{3'd0, 32'h208, 32'h210, 8'd5},
    '{3'd0, 32'h20C, 32'h214, 8'd6},  '{3'd0, 32'h210, 32'h218, 8'd7},
    '{3'd3, 32'h210, 32'h300, 8'd7},  '{3'd0, 32'h214, 32'h21C, 8'd8},
    '{3'd4, 32'h214, 32'h700, 8'd8},  '{3'd0, 32'h218, 32'h220, 8'd9},
    '{3'd1, 32'h218, 32'h400, 8'd9},  '{3'd0, 32'h21C, 32'h224, 8'd10},
    '{3'd0, 32'h400, 32'h408, 8'd11}, '{3'd0, 32'h404, 32'h40C, 8'd12}
  };

  initial begin
    idle();
    repeat (3) @(posedge clk);
    rst_n = 1; #1;
    fetch_req = 1; #1;
    chk("R1 stall", 32'(fetch_stall), 1);
    chk("R1 valid", 32'(fetch_valid), 0);
    chk("R1 unblock", 32'(ublk_valid), 0);
    tick();

    idle(); act_valid = 1; act_tid = 0; act_pc = 32'h100; act_npc = 32'h104; act_nnpc = 32'h108;
    tick();

    for (int i = 0; i < NROW; i++) begin
      idle();
      case (TAB[i].k)
        3'd0: fetch_req = 1;
        3'd1: begin br_valid = 1; br_ctrl = 1; br_taken = 1; end
        3'd2: begin br_valid = 1; br_ctrl = 1; end
        3'd3: begin br_valid = 1; br_ctrl = 1; br_likely = 1; end
        default: begin br_valid = 1; br_ctrl = 0; br_taken = 1; end
      endcase
      if (TAB[i].k != 3'd0) begin br_pc = TAB[i].a; br_target = TAB[i].b; br_seq = TAB[i].s; br_stage = 2'd1; end
      #1;
      case (TAB[i].k)
        3'd0: begin
          chk("R2 R3 R4 addr", fetch_addr, TAB[i].a);
          chk("R3 R4 pred", fetch_pred, TAB[i].b);
          chk("R3 seq", 32'(fetch_seq), 32'(TAB[i].s));
          chk("R3 tid", 32'(fetch_tid), 0);
        end
        3'd1: begin
          chk("R5 sq valid", 32'(sq_req_valid), 1);
          chk("R5 sq seq", 32'(sq_req_seq), 32'(TAB[i].s) + 1);
        end
        3'd2: chk("R6 no squash", 32'(sq_req_valid), 0);
        3'd3: begin
          chk("R7 sq valid", 32'(sq_req_valid), 1);
          chk("R7 sq seq", 32'(sq_req_seq), 32'(TAB[i].s));
        end
        default: chk("R13 no squash", 32'(sq_req_valid), 0);
      endcase
      tick();
    end

    idle(); br_valid = 1; br_ctrl = 1; br_ret = 1; br_seq = 8'd12; br_stage = 2'd2; #1;
    chk("R8 blk", 32'(blk_valid), 1);
    chk("R8 blk stage", 32'(blk_stage), 2);
    chk("R8 no squash", 32'(sq_req_valid), 0);
    tick();
    idle(); fetch_req = 1; #1;
    chk("R8 stall", 32'(fetch_stall), 1);
    tick();

    idle(); sq(0, 0, 8'd20, 1, 0, 32'h0, 32'h800); sq(1, 0, 8'd15, 0, 0, 32'h300, 32'h0); #1;
    chk("R10 unblock", 32'(ublk_valid), 1);
    chk("R10 unblock stage", 32'(ublk_stage[1:0]), 2);
    tick();
    idle(); fetch_req = 1; #1;
    chk("R9 R10 restart", fetch_addr, 32'h304);
    chk("R10 pred", fetch_pred, 32'h30C);
    tick();

    idle(); sq(0, 0, 8'd30, 1, 0, 32'h0, 32'hA00); sq(1, 0, 8'd30, 1, 0, 32'h0, 32'hB00); #1;
    chk("R10 no unblock", 32'(ublk_valid), 0);
    tick();
    fetch("R9 tie", 0, 32'hA00);

    idle(); sq(0, 0, 8'd40, 1, 1, 32'h500, 32'h900); tick();
    fetch("R11 slot", 0, 32'h504);
    fetch("R11 R4 target", 0, 32'h900);
    fetch("R11 after", 0, 32'h904);

    idle(); act_valid = 1; act_tid = 1; act_pc = 32'h1000; act_npc = 32'h1004; act_nnpc = 32'h1008;
    tick();
    idle(); fetch_req = 1; #1;
    chk("R2 seq t1", 32'(fetch_seq), 0);
    tick();
    fetch("R2 rotate", 0, 32'h908);
    fetch("R2 rotate", 1, 32'h1004);

    idle(); deact_valid = 1; deact_tid = 1; tick();
    idle(); sq(0, 1, 8'd1, 1, 0, 32'h0, 32'h2000); br_valid = 1; br_tid = 1; br_ctrl = 1; br_taken = 1; #1;
    chk("R12 no unblock", 32'(ublk_valid), 0);
    chk("R12 no squash", 32'(sq_req_valid), 0);
    tick();
    fetch("R12 only t0", 0, 32'h90C);
    fetch("R12 only t0", 0, 32'h910);
    idle(); deact_valid = 1; deact_tid = 0; tick();
    idle(); fetch_req = 1; #1;
    chk("R12 stall", 32'(fetch_stall), 1);
    tick();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule